// File: doc/BRIEF.md
# Phase-Accumulator Pin Output Generator

This block keeps a 32-bit phase register and, on every clock where it is running, adds a programmable frequency word to that register modulo 2^32. A pin output is derived from the register in one of two ways. In square-wave operation the pin is the register's top bit, which gives a square wave at `f = freq_word * Fsys / 2^32`. For example, a word of 2^32/20 gives one twentieth of the system clock. In density operation the pin is the carry out of the addition just performed, so the fraction of clocks with the pin high is set by the word.

A second pin can be switched on to carry the complement of the first pin, for differential drive. Each pin has its own output enable, and the block also hands out two 6-bit pin indices that a pad multiplexer outside the block uses for routing. A write port loads the phase register directly. The register's value is visible on an output port.

Top module: `phase_pin_gen`

## Requirements
- R1: While `rst` is high and after its release, until the first running clock, `phase_q` is 0 and all four pin and enable outputs are low. Both pin index outputs are 0.
- R2: The mode is `ctrl_word[30:26]`. In modes 1, 2, 3 and 4, each clock without a write sets `phase_q` to the old value plus `freq_word`, modulo 2^32.
- R3: In modes 1 (square, single) and 2 (square, differential), `pin_a_out` equals `phase_q[31]` in the same cycle.
- R4: In modes 3 (density, single) and 4 (density, differential), `pin_a_out` equals the carry out of the addition that produced the current `phase_q`. It is low whenever that addition did not overflow.
- R5: From phase 0 with `freq_word` = 0xF000_0000 in a density mode, the first addition leaves `pin_a_out` low. The next 15 leave it high, and this 16-clock pattern repeats.
- R6: In modes 2 and 4, `pin_b_oe` is 1 and `pin_b_out` is the inverse of `pin_a_out`. In modes 1 and 3, `pin_b_out` and `pin_b_oe` are 0.
- R7: Mode 0 and the unused modes 5 to 31 switch the block off. The phase register holds its value, and `pin_a_out`, `pin_a_oe`, `pin_b_out` and `pin_b_oe` are all 0.
- R8: A `phase_wr_en` pulse loads `phase_wr_data` into `phase_q` at the next edge, in any mode. It takes priority over that clock's addition, and the carry for that clock counts as 0.
- R9: `pin_a_oe` is 1 exactly when the mode sampled at the last edge is 1, 2, 3 or 4.
- R10: One clock after being presented, `pin_a_sel` carries `ctrl_word[5:0]` and `pin_b_sel` carries `ctrl_word[14:9]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 32 | Mode in bits 30..26, first pin index in 5..0, second pin index in 14..9 |
| freq_word | input | 32 | Value added to the phase each running clock |
| phase_wr_en | input | 1 | Load the phase register at this edge |
| phase_wr_data | input | 32 | Value loaded into the phase register |
| phase_q | output | 32 | Current phase register value |
| pin_a_out | output | 1 | Primary pin level |
| pin_a_oe | output | 1 | Primary pin output enable |
| pin_b_out | output | 1 | Complementary pin level |
| pin_b_oe | output | 1 | Complementary pin output enable |
| pin_a_sel | output | 6 | Primary pin index |
| pin_b_sel | output | 6 | Complementary pin index |

## Verification
A phase write and an accumulation can land on the same edge, and so can a write and a mode switch. The bench provokes both by asserting `phase_wr_en` at random, including while the mode changes between running, density and off values. A directed case also writes during a density run that is carrying. In each case the bench expects the written value to win, with no carry for that clock, and it judges the pins from a reference model of the registered state.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    localparam int unsigned CTRL_W    = 32;
    localparam int unsigned MODE_LSB  = 26;
    localparam int unsigned MODE_W    = 5;
    localparam int unsigned SEL_W     = 6;
    localparam int unsigned SELA_LSB  = 0;
    localparam int unsigned SELB_LSB  = 9;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF       = 5'd0,
        MODE_SQ_SE     = 5'd1,
        MODE_SQ_DIFF   = 5'd2,
        MODE_DUTY_SE   = 5'd3,
        MODE_DUTY_DIFF = 5'd4
    } ppg_mode_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_MSB   = 2'd1,
        SRC_CARRY = 2'd2
    } ppg_src_e;

    typedef struct packed {
        ppg_src_e         src;
        logic             diff;
        logic [SEL_W-1:0] sel_a;
        logic [SEL_W-1:0] sel_b;
    } ppg_cfg_t;

    function automatic ppg_cfg_t decode_ctrl(input logic [CTRL_W-1:0] w);
        ppg_cfg_t c;
        logic [MODE_W-1:0] m;
        m       = w[MODE_LSB +: MODE_W];
        c.sel_a = w[SELA_LSB +: SEL_W];
        c.sel_b = w[SELB_LSB +: SEL_W];
        c.src   = SRC_NONE;
        c.diff  = 1'b0;
        case (m)
            MODE_SQ_SE:     c.src = SRC_MSB;
            MODE_SQ_DIFF:   begin c.src = SRC_MSB;   c.diff = 1'b1; end
            MODE_DUTY_SE:   c.src = SRC_CARRY;
            MODE_DUTY_DIFF: begin c.src = SRC_CARRY; c.diff = 1'b1; end
            default:        ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ppg_ctrl.sv
module ppg_ctrl
    import ppg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic              acc_en,
    output ppg_cfg_t          cfg_q
);

    ppg_cfg_t cfg_d;

    always_comb begin
        cfg_d  = decode_ctrl(ctrl_word);
        acc_en = (cfg_d.src != SRC_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    AST_DIFF_NEEDS_SRC: assert property (@(posedge clk) disable iff (rst)
        cfg_q.diff |-> (cfg_q.src != SRC_NONE)); // R6

endmodule

// File: rtl/ppg_accum.sv
module ppg_accum #(
    parameter int unsigned PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_en,
    input  logic [PHASE_W-1:0] freq,
    input  logic               wr_en,
    input  logic [PHASE_W-1:0] wr_data,
    output logic [PHASE_W-1:0] phase_q,
    output logic               carry_q
);

    localparam int unsigned SUM_W = PHASE_W + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = {1'b0, phase_q} + {1'b0, freq};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            carry_q <= 1'b0;
        end else if (wr_en) begin
            phase_q <= wr_data;
            carry_q <= 1'b0;
        end else if (acc_en) begin
            phase_q <= sum[PHASE_W-1:0];
            carry_q <= sum[PHASE_W];
        end else begin
            carry_q <= 1'b0;
        end
    end

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (phase_q == $past(wr_data)) && !carry_q); // R8

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !acc_en) |=> $stable(phase_q)); // R7

    AST_ACCUM_STEP: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && acc_en) |=> (phase_q == $past(phase_q) + $past(freq))); // R2

endmodule

// File: rtl/ppg_pin_drive.sv
module ppg_pin_drive
    import ppg_pkg::*;
#(
    parameter int unsigned PHASE_W = 32
) (
    input  ppg_cfg_t           cfg,
    input  logic [PHASE_W-1:0] phase,
    input  logic               carry,
    output logic               pin_a,
    output logic               oe_a,
    output logic               pin_b,
    output logic               oe_b
);

    logic level;

    always_comb begin
        unique case (cfg.src)
            SRC_MSB:   level = phase[PHASE_W-1];
            SRC_CARRY: level = carry;
            default:   level = 1'b0;
        endcase
        oe_a  = (cfg.src != SRC_NONE);
        oe_b  = oe_a && cfg.diff;
        pin_a = level;
        pin_b = oe_b ? ~level : 1'b0;
    end

endmodule

// File: rtl/phase_pin_gen.sv
module phase_pin_gen
    import ppg_pkg::*;
#(
    parameter int unsigned PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CTRL_W-1:0]  ctrl_word,
    input  logic [PHASE_W-1:0] freq_word,
    input  logic               phase_wr_en,
    input  logic [PHASE_W-1:0] phase_wr_data,
    output logic [PHASE_W-1:0] phase_q,
    output logic               pin_a_out,
    output logic               pin_a_oe,
    output logic               pin_b_out,
    output logic               pin_b_oe,
    output logic [SEL_W-1:0]   pin_a_sel,
    output logic [SEL_W-1:0]   pin_b_sel
);

    logic     acc_en;
    logic     carry_q;
    ppg_cfg_t cfg_q;

    ppg_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctrl_word (ctrl_word),
        .acc_en    (acc_en),
        .cfg_q     (cfg_q)
    );

    ppg_accum #(.PHASE_W(PHASE_W)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .acc_en  (acc_en),
        .freq    (freq_word),
        .wr_en   (phase_wr_en),
        .wr_data (phase_wr_data),
        .phase_q (phase_q),
        .carry_q (carry_q)
    );

    ppg_pin_drive #(.PHASE_W(PHASE_W)) u_drive (
        .cfg   (cfg_q),
        .phase (phase_q),
        .carry (carry_q),
        .pin_a (pin_a_out),
        .oe_a  (pin_a_oe),
        .pin_b (pin_b_out),
        .oe_b  (pin_b_oe)
    );

    assign pin_a_sel = cfg_q.sel_a;
    assign pin_b_sel = cfg_q.sel_b;

    AST_DIFF_INVERSE: assert property (@(posedge clk) disable iff (rst)
        pin_b_oe |-> (pin_b_out == !pin_a_out) && pin_a_oe); // R6

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !pin_a_oe |-> !pin_a_out && !pin_b_out && !pin_b_oe); // R7

    AST_SEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pin_a_sel == $past(ctrl_word[5:0])) && (pin_b_sel == $past(ctrl_word[14:9]))); // R10

    AST_NO_CARRY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (phase_wr_en && (ctrl_word[30:26] == 5'd3)) |=> !pin_a_out); // R8

endmodule

// File: tb/test_phase_pin_gen.sv
module test_phase_pin_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ctrl_word = '0;
    logic [31:0] freq_word = '0;
    logic        phase_wr_en = 1'b0;
    logic [31:0] phase_wr_data = '0;
    logic [31:0] phase_q;
    logic        pin_a_out, pin_a_oe, pin_b_out, pin_b_oe;
    logic [5:0]  pin_a_sel, pin_b_sel;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          finished = 0;

    // reference model state
    logic [31:0] m_phase = '0;
    logic        m_carry = 1'b0;
    logic [4:0]  m_mode  = '0;
    logic [5:0]  m_sa    = '0;
    logic [5:0]  m_sb    = '0;

    always #5 clk = ~clk;

    phase_pin_gen i_phase_pin_gen (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .freq_word(freq_word),
        .phase_wr_en(phase_wr_en), .phase_wr_data(phase_wr_data),
        .phase_q(phase_q), .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe),
        .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe),
        .pin_a_sel(pin_a_sel), .pin_b_sel(pin_b_sel)
    );

    function automatic bit is_run(input logic [4:0] m);
        return (m >= 5'd1) && (m <= 5'd4);
    endfunction

    function automatic logic [31:0] mk_ctrl(input logic [4:0] m, input logic [5:0] a, input logic [5:0] b);
        return {1'b0, m, 11'($urandom), b, 3'($urandom), a};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: model update from inputs, then compare after the edge
    task automatic tick();
        logic [32:0] s;
        logic        run, ea, eb, diff;
        string       ta, tp;
        m_mode = ctrl_word[30:26];
        run    = is_run(m_mode);
        s      = {1'b0, m_phase} + {1'b0, freq_word};
        if (phase_wr_en) begin
            m_phase = phase_wr_data; m_carry = 1'b0; tp = "R8";
        end else if (run) begin
            m_phase = s[31:0]; m_carry = s[32]; tp = "R2";
        end else begin
            m_carry = 1'b0; tp = "R7";
        end
        m_sa = ctrl_word[5:0];
        m_sb = ctrl_word[14:9];
        @(posedge clk);
        #1;
        diff = (m_mode == 5'd2) || (m_mode == 5'd4);
        if (!run)                                   begin ea = 1'b0; ta = "R7"; end
        else if (m_mode == 5'd1 || m_mode == 5'd2) begin ea = m_phase[31]; ta = "R3"; end
        else                                        begin ea = m_carry; ta = (tp == "R8") ? "R8" : "R4"; end
        eb = (run && diff) ? ~ea : 1'b0;
        chk(tp, phase_q, m_phase);
        chk(ta, 32'(pin_a_out), 32'(ea));
        chk(run ? "R6" : "R7", 32'(pin_b_out), 32'(eb));
        chk(run ? "R6" : "R7", 32'(pin_b_oe), 32'(run && diff));
        chk("R9", 32'(pin_a_oe), 32'(run));
        chk("R10", {26'd0, pin_a_sel}, {26'd0, m_sa});
        chk("R10", {26'd0, pin_b_sel}, {26'd0, m_sb});
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        @(negedge clk);
        ctrl_word = mk_ctrl(5'd2, 6'd7, 6'd9);
        freq_word = 32'h1234_5678;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", phase_q, 32'd0);
        chk("R1", {28'd0, pin_a_out, pin_a_oe, pin_b_out, pin_b_oe}, 32'd0);
        chk("R1", {20'd0, pin_a_sel, pin_b_sel}, 32'd0);
        rst = 1'b0;
        ctrl_word = '0;
        tick();

        // R5: 0xF000_0000 density pattern from phase 0
        ctrl_word = mk_ctrl(5'd4, 6'd1, 6'd2);
        freq_word = 32'hF000_0000;
        for (int k = 0; k < 40; k++) begin
            tick();
            chk("R5", 32'(pin_a_out), 32'((k % 16) != 0));
        end

        // R8: write during a carrying density run
        phase_wr_en = 1'b1; phase_wr_data = 32'hFFFF_FFF0;
        tick();
        chk("R8", 32'(pin_a_out), 32'd0);
        phase_wr_en = 1'b0;
        freq_word = 32'h0000_0020;
        tick();
        chk("R4", 32'(pin_a_out), 32'd1);

        // R3: square wave at Fsys/20
        ctrl_word = mk_ctrl(5'd1, 6'd3, 6'd4);
        freq_word = 32'd214748365;
        phase_wr_en = 1'b1; phase_wr_data = '0;
        tick();
        phase_wr_en = 1'b0;
        for (int k = 0; k < 40; k++) tick();

        // R7: reserved mode holds, write while off still loads
        ctrl_word = mk_ctrl(5'd17, 6'd5, 6'd6);
        for (int k = 0; k < 4; k++) tick();
        phase_wr_en = 1'b1; phase_wr_data = 32'h8000_0000;
        tick();
        phase_wr_en = 1'b0;
        tick();

        // random mix
        for (int k = 0; k < 600; k++) begin
            logic [4:0] m;
            m = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % 5);
            ctrl_word     = mk_ctrl(m, 6'($urandom), 6'($urandom));
            freq_word     = ($urandom % 3 == 0) ? 32'hFFFF_FFFF - ($urandom % 16) : $urandom;
            phase_wr_en   = ($urandom % 8 == 0);
            phase_wr_data = $urandom;
            tick();
        end
        phase_wr_en = 1'b0;

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule